// File: doc/BRIEF.md
# Clock Output Enable and Runt-Free Gating Bank

This block sits between a shared internal source clock and a bank of clock output channels. For each channel it produces two things: the clock level to drive and a tri-state enable for the pad. Together they put the channel in one of three states: high-impedance, running (the source clock, optionally inverted) or parked at a static level.

The tri-state enables are purely combinational. A global tri-state input overrides everything. When it is inactive, a per-channel two-bit mode selects one of four behaviours: always driven, never driven, or driven under one of two secondary enable pins. The global input also drops a separate feedback-driver enable, which tells the rest of the chip that lock will be lost.

A gate pin parks the selected channels without ever tri-stating them. The pin is synchronized to the source clock. Each park or release takes effect only on a falling edge of the source clock, so no channel emits a shortened pulse. A parked channel rests at the level given by its polarity bit.

Top module: `clk_out_bank`

## Requirements
- R1: While `globalTristate` is 1, every bit of `outEnable` is 0, whatever the mode, secondary enables or gate.
- R2: While `globalTristate` is 0, a channel's `outEnable` follows its 2-bit mode field `cfgMode[2i+1:2i]`. The encodings are 2'b00 always 1, 2'b01 always 0, 2'b10 equal to `secEnA`, and 2'b11 equal to `secEnB`; both secondary pins are active high.
- R3: `fbDriveEn` is 0 while `globalTristate` is 1 and 1 while it is 0.
- R4: The gate pin never changes any bit of `outEnable`.
- R5: A parked channel drives `cfgInvert[i]`: low for true polarity (0) and high for inverted polarity (1). A running channel drives `srcClk` XOR `cfgInvert[i]`.
- R6: While the gate toggles at arbitrary times, no high or low pulse on any `clkLevel` bit is shorter than half a source period.
- R7: A channel with `cfgGateSel[i]` = 0 ignores the gate pin and keeps running.
- R8: `outEnable` and `fbDriveEn` respond to the enable pins while `srcClk` is stopped.
- R9: `gateRun` is sampled on rising edges of `srcClk` through two flops. A selected channel parks (when the sampled value is 0) or releases (when it is 1) at the falling edge that follows the second rising edge after the change. Reset leaves every channel running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Shared internal source clock |
| rstN | input | 1 | Asynchronous reset, active low |
| globalTristate | input | 1 | 1 forces every channel to high-impedance |
| secEnA | input | 1 | First secondary enable, active high |
| secEnB | input | 1 | Second secondary enable, active high |
| gateRun | input | 1 | Synchronous gate: 0 parks the selected channels, 1 lets them run |
| cfgMode | input | 2*NUM_CH | Per-channel enable mode, 2 bits per channel |
| cfgInvert | input | NUM_CH | Per-channel polarity, 1 = inverted |
| cfgGateSel | input | NUM_CH | Per-channel response to the gate pin, 1 = responds |
| clkLevel | output | NUM_CH | Driven clock level per channel |
| outEnable | output | NUM_CH | Tri-state driver enable per channel, 1 = driven |
| fbDriveEn | output | 1 | Feedback-path driver enable; 0 means lock will be lost |

## Verification
The enable logic is tried with every combination of global tri-state, both secondary pins and all four modes. This separates an override fault from a mode-decode fault and from swapped secondary pins. The same logic is tried with the source clock halted, which exposes any enable that was accidentally registered. The gating path is tried with a mixed bank of true, inverted, selected and unselected channels while the gate toggles at random phases of the clock. A reference model compares every half period, so an off-by-one in synchronizer depth, a wrong park level, a rising-edge update or an unselected channel that reacts all show up, and pulse-width measurement catches any runt.

// File: rtl/clk_bank_pkg.sv
package clk_bank_pkg;

  typedef enum logic [1:0] {
    MODE_ON    = 2'b00,
    MODE_OFF   = 2'b01,
    MODE_SEC_A = 2'b10,
    MODE_SEC_B = 2'b11
  } enMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic gateRunSync;  // gate pin after the synchronizer
    logic driversOff;   // global tri-state active
  } ctlStrobes_t;

endpackage

// File: rtl/clk_bank_ctl.sv
module clk_bank_ctl
  import clk_bank_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  srcClk,
  input  logic                  rstN,
  input  logic                  globalTristate,
  input  logic                  secEnA,
  input  logic                  secEnB,
  input  logic                  gateRun,
  input  logic [2*NUM_CH-1:0]   cfgMode,
  output logic [NUM_CH-1:0]     outEnable,
  output logic                  fbDriveEn,
  output ctlStrobes_t           strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  // Gate synchronizer; reset value means "run"
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[LAST-1:0], gateRun};
  end

  assign strobes.gateRunSync = syncQ[LAST];
  assign strobes.driversOff  = globalTristate;
  assign fbDriveEn           = ~globalTristate;

  // Enable decode: combinational only, independent of the clock
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_en
    enMode_e modeSel;
    logic    modeEn;
    assign modeSel = enMode_e'(cfgMode[2*ch +: 2]);
    always_comb begin
      unique case (modeSel)
        MODE_ON:    modeEn = 1'b1;
        MODE_OFF:   modeEn = 1'b0;
        MODE_SEC_A: modeEn = secEnA;
        MODE_SEC_B: modeEn = secEnB;
        default:    modeEn = 1'b0;
      endcase
    end
    assign outEnable[ch] = modeEn & ~globalTristate;
  end

endmodule

// File: rtl/clk_bank_dp.sv
module clk_bank_dp
  import clk_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              srcClk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [NUM_CH-1:0] cfgInvert,
  input  logic [NUM_CH-1:0] cfgGateSel,
  output logic [NUM_CH-1:0] clkLevel
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic parkQ;

    // Park state moves only on the falling edge, while the true clock is low,
    // so entry and exit never cut a pulse short.
    always_ff @(negedge srcClk or negedge rstN) begin
      if (!rstN) parkQ <= 1'b0;
      else       parkQ <= cfgGateSel[ch] & ~strobes.gateRunSync;
    end

    assign clkLevel[ch] = parkQ ? cfgInvert[ch] : (srcClk ^ cfgInvert[ch]);
  end

endmodule

// File: rtl/clk_out_bank.sv
module clk_out_bank
  import clk_bank_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                srcClk,
  input  logic                rstN,
  input  logic                globalTristate,
  input  logic                secEnA,
  input  logic                secEnB,
  input  logic                gateRun,
  input  logic [2*NUM_CH-1:0] cfgMode,
  input  logic [NUM_CH-1:0]   cfgInvert,
  input  logic [NUM_CH-1:0]   cfgGateSel,
  output logic [NUM_CH-1:0]   clkLevel,
  output logic [NUM_CH-1:0]   outEnable,
  output logic                fbDriveEn
);

  ctlStrobes_t strobes;

  clk_bank_ctl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .srcClk(srcClk), .rstN(rstN), .globalTristate(globalTristate),
    .secEnA(secEnA), .secEnB(secEnB), .gateRun(gateRun),
    .cfgMode(cfgMode), .outEnable(outEnable), .fbDriveEn(fbDriveEn),
    .strobes(strobes)
  );

  clk_bank_dp #(.NUM_CH(NUM_CH)) u_dp (
    .srcClk(srcClk), .rstN(rstN), .strobes(strobes),
    .cfgInvert(cfgInvert), .cfgGateSel(cfgGateSel), .clkLevel(clkLevel)
  );

endmodule

// File: rtl/clk_bank_chk.sv
module clk_bank_chk
  import clk_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                srcClk,
  input logic                rstN,
  input logic                globalTristate,
  input logic [2*NUM_CH-1:0] cfgMode,
  input logic [NUM_CH-1:0]   cfgInvert,
  input logic [NUM_CH-1:0]   cfgGateSel,
  input logic [NUM_CH-1:0]   clkLevel,
  input logic [NUM_CH-1:0]   outEnable,
  input logic                fbDriveEn,
  input ctlStrobes_t         strobes
);

  assert_all_hiz_R1: assert property (@(posedge srcClk) disable iff (!rstN)
    globalTristate |-> (outEnable == '0));

  assert_fb_off_R3: assert property (@(posedge srcClk) disable iff (!rstN)
    globalTristate |-> !fbDriveEn);

  assert_fb_on_R3: assert property (@(posedge srcClk) disable iff (!rstN)
    !globalTristate |-> fbDriveEn);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_mode_on_R2: assert property (@(posedge srcClk) disable iff (!rstN)
      (!globalTristate && cfgMode[2*ch +: 2] == 2'b00) |-> outEnable[ch]);

    assert_mode_off_R2: assert property (@(posedge srcClk) disable iff (!rstN)
      (cfgMode[2*ch +: 2] == 2'b01) |-> !outEnable[ch]);

    // Sampled at the falling edge, where a running channel shows ~cfgInvert.
    assert_park_level_R5: assert property (@(negedge srcClk) disable iff (!rstN)
      (cfgGateSel[ch] && $past(cfgGateSel[ch]) && !$past(strobes.gateRunSync))
        |-> (clkLevel[ch] == cfgInvert[ch]));

    assert_run_level_R5: assert property (@(negedge srcClk) disable iff (!rstN)
      (cfgGateSel[ch] && $past(cfgGateSel[ch]) && $past(strobes.gateRunSync))
        |-> (clkLevel[ch] != cfgInvert[ch]));

    assert_unselected_runs_R7: assert property (@(negedge srcClk) disable iff (!rstN)
      (!cfgGateSel[ch] && !$past(cfgGateSel[ch]))
        |-> (clkLevel[ch] != cfgInvert[ch]));
  end

endmodule

bind clk_out_bank clk_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .srcClk(srcClk), .rstN(rstN), .globalTristate(globalTristate),
  .cfgMode(cfgMode), .cfgInvert(cfgInvert), .cfgGateSel(cfgGateSel),
  .clkLevel(clkLevel), .outEnable(outEnable), .fbDriveEn(fbDriveEn),
  .strobes(strobes)
);

// File: tb/sim_clk_out_bank.sv
`timescale 1ns/1ps
module sim_clk_out_bank;
  localparam int  N    = 4;
  localparam real HALF = 2.5;   // 200 MHz

  logic srcClk = 0, clkRun = 1, rstN = 0;
  logic globalTristate = 0, secEnA = 0, secEnB = 0, gateRun = 1;
  logic [2*N-1:0] cfgMode = '0;
  logic [N-1:0]   cfgInvert = '0, cfgGateSel = '0;
  wire  [N-1:0]   clkLevel, outEnable;
  wire            fbDriveEn;

  int compared = 0, mismatched = 0;
  bit gateQ[$] = '{1'b1, 1'b1};
  bit parkM[N];
  bit widthWatch = 0;
  int runts[N], pulses[N];
  realtime lastEdge[N];

  clk_out_bank #(.NUM_CH(N)) u0 (
    .srcClk(srcClk), .rstN(rstN), .globalTristate(globalTristate),
    .secEnA(secEnA), .secEnB(secEnB), .gateRun(gateRun),
    .cfgMode(cfgMode), .cfgInvert(cfgInvert), .cfgGateSel(cfgGateSel),
    .clkLevel(clkLevel), .outEnable(outEnable), .fbDriveEn(fbDriveEn)
  );

  always #(HALF) if (clkRun) srcClk = ~srcClk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expEn(input int i);
    if (globalTristate) return 1'b0;
    case (cfgMode[2*i +: 2])
      2'b00:   return 1'b1;
      2'b01:   return 1'b0;
      2'b10:   return secEnA;
      default: return secEnB;
    endcase
  endfunction

  // Reference model: history of gate samples taken at rising edges
  always @(posedge srcClk) begin
    if (!rstN) gateQ = '{1'b1, 1'b1};
    else begin
      gateQ.push_back(gateRun);
      if (gateQ.size() > 4) void'(gateQ.pop_front());
    end
  end

  // R9: park decided at the falling edge from the sample two rising edges back
  always @(negedge srcClk) begin
    for (int i = 0; i < N; i++)
      parkM[i] = rstN && cfgGateSel[i] && !gateQ[gateQ.size()-2];
  end

  // Compare every half period, mid-phase
  always @(srcClk) begin
    if (rstN) begin
      #(HALF/2);
      for (int i = 0; i < N; i++) begin
        bit expLvl;
        expLvl = parkM[i] ? cfgInvert[i] : (srcClk ^ cfgInvert[i]);
        check(clkLevel[i] == expLvl, cfgGateSel[i] ? "R5 R9" : "R7",
              $sformatf("clkLevel[%0d]", i), clkLevel[i], expLvl);
        check(outEnable[i] == expEn(i), globalTristate ? "R1" : "R2",
              $sformatf("outEnable[%0d]", i), outEnable[i], expEn(i));
      end
    end
  end

  // R6: pulse-width monitors
  for (genvar g = 0; g < N; g++) begin : g_mon
    always @(clkLevel[g]) begin
      if (widthWatch) begin
        pulses[g]++;
        if ($realtime - lastEdge[g] < HALF - 0.01) runts[g]++;
      end
      lastEdge[g] = $realtime;
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000.0 * 2 * HALF);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  real offs[6] = '{0.6, 1.3, 1.9, 3.1, 3.7, 4.4};

  initial begin
    // Reset state: channels run, enables from mode 00
    repeat (3) @(posedge srcClk);
    #1.0;
    check(clkLevel == '1, "R9", "reset clkLevel high phase", clkLevel, 4'hF);
    check(outEnable == '1, "R2", "reset outEnable", outEnable, 4'hF);
    check(fbDriveEn == 1'b1, "R3", "reset fbDriveEn", fbDriveEn, 1);
    @(negedge srcClk); #1.0 rstN = 1;

    // Full enable truth table
    for (int gt = 0; gt < 2; gt++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          for (int m = 0; m < 4; m++) begin
            @(posedge srcClk); #0.6;
            globalTristate = gt[0]; secEnA = a[0]; secEnB = b[0];
            cfgMode = {N{m[1:0]}};
            #0.3;
            for (int i = 0; i < N; i++)
              check(outEnable[i] == expEn(i), gt ? "R1" : "R2",
                    $sformatf("table gt%0d a%0d b%0d m%0d ch%0d", gt, a, b, m, i),
                    outEnable[i], expEn(i));
            check(fbDriveEn == !gt[0], "R3", "table fbDriveEn", fbDriveEn, !gt[0]);
          end

    // R8: enables with the clock halted
    @(posedge srcClk); #0.6;
    globalTristate = 0; cfgMode = 8'b11_10_11_10; secEnA = 0; secEnB = 0;
    clkRun = 0;
    #20;
    secEnA = 1; #0.5;
    check(outEnable == 4'b0101, "R8", "stopped clock secEnA", outEnable, 4'b0101);
    secEnB = 1; #0.5;
    check(outEnable == 4'b1111, "R8", "stopped clock secEnB", outEnable, 4'b1111);
    globalTristate = 1; #0.5;
    check(outEnable == 4'b0000, "R8", "stopped clock tristate", outEnable, 0);
    check(fbDriveEn == 1'b0, "R8", "stopped clock fbDriveEn", fbDriveEn, 0);
    globalTristate = 0; #0.5;
    clkRun = 1;

    // Gating with a mixed bank: ch2 unselected
    @(posedge srcClk); #0.6;
    cfgMode = '0; cfgInvert = 4'b1010; cfgGateSel = 4'b1011;
    repeat (3) @(posedge srcClk);
    widthWatch = 1;
    for (int k = 0; k < 80; k++) begin
      repeat ($urandom_range(1, 5)) @(posedge srcClk);
      #(offs[$urandom_range(0, 5)]);
      gateRun = ~gateRun;
      #0.2;
      check(outEnable == 4'b1111, "R4", "outEnable after gate toggle", outEnable, 4'b1111);
    end
    // Hold parked and look at the high phase
    @(posedge srcClk); #0.6 gateRun = 0;
    repeat (4) @(posedge srcClk);
    #1.2;
    check(clkLevel == 4'b1110, "R5", "parked levels high phase", clkLevel, 4'b1110);
    check(clkLevel[2] == 1'b1, "R7", "unselected runs", clkLevel[2], 1);
    @(negedge srcClk); #1.2;
    check(clkLevel == 4'b1010, "R5", "parked levels low phase", clkLevel, 4'b1010);
    gateRun = 1;
    repeat (4) @(posedge srcClk);
    widthWatch = 0;
    for (int i = 0; i < N; i++) begin
      check(runts[i] == 0, "R6", $sformatf("runt count ch%0d", i), runts[i], 0);
      check(pulses[i] > 20, "R6", $sformatf("pulse activity ch%0d", i), pulses[i], 21);
    end

    // Tri-state while parked: gate cannot re-enable
    @(posedge srcClk); #0.6 gateRun = 0; globalTristate = 1;
    repeat (4) @(posedge srcClk);
    #1.0;
    check(outEnable == '0, "R1", "tristate while parked", outEnable, 0);
    globalTristate = 0; gateRun = 1;
    repeat (4) @(posedge srcClk);
    #1.0;
    finishRun();
  end

endmodule